// File: doc/BRIEF.md
# Memory Access and Next-PC Unit

This unit handles the memory stage and the program-counter choice for a small 64-bit processor whose memory is 16 bits wide and word-addressed with 24-bit addresses. A start pulse presents an instruction's opcode together with the ALU result, the register operand, the sequential return address, the immediate target and the evaluated branch condition. From the opcode the unit decides whether memory is touched. If it is, the unit also decides which address source and which write source are used.

A 64-bit load or store is split into four single-word transfers on consecutive addresses, one per cycle, with the most significant word first. Reads are assembled into a 64-bit result. Once the access ends, the unit pulses done and presents the next PC, which may come from the sequential address, the immediate target or the value just read from the stack.

Pops and returns address memory through the stack pointer as it was before the instruction. The adjusted pointer comes from the ALU and is written back elsewhere.

Top module: `mem_nextpc_unit`

## Requirements
- R1: The word address comes from the low 24 bits of val_e for opcodes 4, 5, 8 and 10, and from the low 24 bits of val_a for opcodes 9 and 11. The upper 40 bits of the chosen source have no effect.
- R2: Only opcodes 4, 8 and 10 assert mem_we. Opcodes 4 and 10 store val_a, and opcode 8 stores val_p.
- R3: Opcodes 5, 9 and 11 read 64 bits into val_m, with the word read first placed in bits 63:48. All other opcodes leave val_m unchanged.
- R4: A memory access is exactly four consecutive cycles with mem_req high. The addresses are base, base+1, base+2 and base+3, modulo 2^24, and mem_we holds one value for the whole access.
- R5: Store data goes out most significant word first: bits 63:48 at the base address, and bits 15:0 at base+3.
- R6: done is high for a single cycle, in the cycle after the fourth word cycle. It is therefore the fifth cycle after the start edge.
- R7: Opcodes 0-3, 6, 7 and 12-15 raise done in the first cycle after the start edge and never assert mem_req.
- R8: While done is high, next_pc equals:
  - val_c for opcode 7 when cond_ok is 1, and val_p for opcode 7 when cond_ok is 0;
  - val_c for opcode 8;
  - the value read, val_m, for opcode 9;
  - val_p for every other opcode.
- R9: A start pulse during a transfer is ignored, and so are operand changes after the start edge. The running access completes with the values captured at start.
- R10: After reset, done and mem_req are low and val_m is zero.
- R11: mem_rdata is sampled at the clock edge that ends each read word cycle, and mem_wdata is valid during the word cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches processing of the presented instruction |
| opcode | input | 4 | Instruction opcode |
| cond_ok | input | 1 | Evaluated branch condition |
| val_e | input | 64 | ALU result |
| val_a | input | 64 | Register operand (store data or stack pointer) |
| val_p | input | 64 | Address of the following instruction |
| val_c | input | 64 | Immediate target |
| mem_req | output | 1 | A word transfer takes place this cycle |
| mem_we | output | 1 | The word transfer is a write |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word returned for mem_addr |
| val_m | output | 64 | Assembled read value |
| done | output | 1 | One-cycle completion strobe |
| next_pc | output | 64 | Selected next program counter, valid with done |

## Verification
The bench sweeps all sixteen opcodes with the condition bit both low and high, and puts garbage in the upper address bits. A unit that used the post-increment pointer or the wrong operand would show a wrong first address, and one that decoded the write set wrongly would show a stray or missing write strobe. Bursts that start two words below the top of the address space catch an address adder that carries into a 25th bit or fails to wrap. A start pulse injected mid-transfer with changed operands shows whether the unit relaunches or re-captures. The read value is checked word by word, so reversing the order of the words shows up, and the return target for opcode 9 confirms that next_pc follows the assembled value and not the pointer.

// File: rtl/mnp_pkg.sv
package mnp_pkg;

    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_LOAD  = 4'h5;
    localparam logic [3:0] OPC_JUMP  = 4'h7;
    localparam logic [3:0] OPC_CALL  = 4'h8;
    localparam logic [3:0] OPC_RET   = 4'h9;
    localparam logic [3:0] OPC_PUSH  = 4'hA;
    localparam logic [3:0] OPC_POP   = 4'hB;

    typedef enum logic [1:0] {ASRC_NONE, ASRC_ALU, ASRC_PTR} addr_src_e;
    typedef enum logic [1:0] {WSRC_NONE, WSRC_REG, WSRC_LINK} wdata_src_e;
    typedef enum logic [1:0] {PCS_SEQ, PCS_TARGET, PCS_STACK} pc_src_e;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} seq_state_e;

    typedef struct packed {
        addr_src_e  asrc;
        wdata_src_e wsrc;
        logic       rd;
        logic       wr;
    } mem_ctrl_t;

    function automatic mem_ctrl_t decode_mem(input logic [3:0] op);
        mem_ctrl_t c;
        c = '{asrc: ASRC_NONE, wsrc: WSRC_NONE, rd: 1'b0, wr: 1'b0};
        unique case (op)
            OPC_STORE, OPC_PUSH: c = '{asrc: ASRC_ALU, wsrc: WSRC_REG,  rd: 1'b0, wr: 1'b1};
            OPC_CALL:            c = '{asrc: ASRC_ALU, wsrc: WSRC_LINK, rd: 1'b0, wr: 1'b1};
            OPC_LOAD:            c = '{asrc: ASRC_ALU, wsrc: WSRC_NONE, rd: 1'b1, wr: 1'b0};
            OPC_RET, OPC_POP:    c = '{asrc: ASRC_PTR, wsrc: WSRC_NONE, rd: 1'b1, wr: 1'b0};
            default: ;
        endcase
        return c;
    endfunction

    function automatic pc_src_e decode_pc(input logic [3:0] op, input logic cond);
        pc_src_e s;
        unique case (op)
            OPC_JUMP: s = cond ? PCS_TARGET : PCS_SEQ;
            OPC_CALL: s = PCS_TARGET;
            OPC_RET:  s = PCS_STACK;
            default:  s = PCS_SEQ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mnp_decode.sv
module mnp_decode
    import mnp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 24
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] val_e,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_p,
    output mem_ctrl_t         ctrl,
    output logic [ADDR_W-1:0] base_addr,
    output logic [DATA_W-1:0] wr_data
);

    always_comb begin
        ctrl = decode_mem(opcode);
        unique case (ctrl.asrc)
            ASRC_ALU: base_addr = val_e[ADDR_W-1:0];
            ASRC_PTR: base_addr = val_a[ADDR_W-1:0];
            default:  base_addr = '0;
        endcase
        unique case (ctrl.wsrc)
            WSRC_REG:  wr_data = val_a;
            WSRC_LINK: wr_data = val_p;
            default:   wr_data = '0;
        endcase
    end

endmodule

// File: rtl/mnp_seq.sv
module mnp_seq
    import mnp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  mem_ctrl_t         ctrl,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] val_m,
    output logic              done
);

    localparam int WORDS = DATA_W / WORD_W;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              rd_q;
    logic              wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            wbuf_q  <= '0;
            rbuf_q  <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_XFER: begin
                    wbuf_q <= wbuf_q << WORD_W;
                    if (rd_q)
                        rbuf_q <= {rbuf_q[DATA_W-WORD_W-1:0], mem_rdata};
                    if (idx_q == LAST_IDX) begin
                        idx_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    if (launch) begin
                        base_q <= base_addr;
                        wbuf_q <= wr_data;
                        rd_q   <= ctrl.rd;
                        wr_q   <= ctrl.wr;
                        idx_q  <= '0;
                        state_q <= (ctrl.rd || ctrl.wr) ? ST_XFER : ST_DONE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy      = (state_q == ST_XFER);
    assign mem_req   = busy;
    assign mem_we    = busy && wr_q;
    assign mem_addr  = base_q + ADDR_W'(idx_q);
    assign mem_wdata = wbuf_q[DATA_W-1 -: WORD_W];
    assign val_m     = rbuf_q;
    assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/mnp_pc_sel.sv
module mnp_pc_sel
    import mnp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        opcode,
    input  logic              cond_ok,
    input  logic [DATA_W-1:0] val_p,
    input  logic [DATA_W-1:0] val_c,
    input  logic [DATA_W-1:0] val_m,
    output logic [DATA_W-1:0] next_pc
);

    always_comb begin
        unique case (decode_pc(opcode, cond_ok))
            PCS_TARGET: next_pc = val_c;
            PCS_STACK:  next_pc = val_m;
            default:    next_pc = val_p;
        endcase
    end

endmodule

// File: rtl/mem_nextpc_unit.sv
module mem_nextpc_unit
    import mnp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        opcode,
    input  logic              cond_ok,
    input  logic [DATA_W-1:0] val_e,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_p,
    input  logic [DATA_W-1:0] val_c,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] val_m,
    output logic              done,
    output logic [DATA_W-1:0] next_pc
);

    mem_ctrl_t         ctrl;
    logic [ADDR_W-1:0] base_addr;
    logic [DATA_W-1:0] wr_data;
    logic              busy;
    logic              launch;

    logic [3:0]        op_q;
    logic              cond_q;
    logic [DATA_W-1:0] p_q;
    logic [DATA_W-1:0] c_q;

    assign launch = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            cond_q <= 1'b0;
            p_q    <= '0;
            c_q    <= '0;
        end else if (launch) begin
            op_q   <= opcode;
            cond_q <= cond_ok;
            p_q    <= val_p;
            c_q    <= val_c;
        end
    end

    mnp_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .opcode    (opcode),
        .val_e     (val_e),
        .val_a     (val_a),
        .val_p     (val_p),
        .ctrl      (ctrl),
        .base_addr (base_addr),
        .wr_data   (wr_data)
    );

    mnp_seq #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ctrl      (ctrl),
        .base_addr (base_addr),
        .wr_data   (wr_data),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .val_m     (val_m),
        .done      (done)
    );

    mnp_pc_sel #(.DATA_W(DATA_W)) u_pc_sel (
        .opcode  (op_q),
        .cond_ok (cond_q),
        .val_p   (p_q),
        .val_c   (c_q),
        .val_m   (val_m),
        .next_pc (next_pc)
    );

endmodule

// File: rtl/mnp_checker.sv
module mnp_checker #(
    parameter int ADDR_W = 24,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);

    localparam int CNT_W = $clog2(WORDS + 1) + 1;

    logic [CNT_W-1:0] burst_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            burst_cnt <= '0;
        else if (done)
            burst_cnt <= '0;
        else if (mem_req)
            burst_cnt <= burst_cnt + 1'b1;
    end

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);                                                  // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + 1'b1);   // R4
    AST_WE_STEADY: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req) |-> mem_we == $past(mem_we));              // R4
    AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
        done |-> (burst_cnt == '0 || burst_cnt == CNT_W'(WORDS)));           // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done);                                            // R6
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        $past(done) && !$past(start) |-> !mem_req);                           // R7

endmodule

bind mem_nextpc_unit mnp_checker #(.ADDR_W(ADDR_W), .WORDS(DATA_W / WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/mem_nextpc_unit_tb.sv
module mem_nextpc_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  opcode;
    logic        cond_ok;
    logic [63:0] val_e, val_a, val_p, val_c;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [63:0] val_m, next_pc;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [23:0] ad);
        return (16'(ad[7:0]) * 16'h0107) ^ 16'h3C00;
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    mem_nextpc_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .cond_ok(cond_ok),
        .val_e(val_e), .val_a(val_a), .val_p(val_p), .val_c(val_c),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .val_m(val_m),
        .done(done), .next_pc(next_pc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic c,
                          input logic [63:0] e, input logic [63:0] a,
                          input logic [63:0] p, input logic [63:0] t,
                          input bit poke);
        bit          is_rd, is_wr, is_mem;
        logic [23:0] base, prev, first;
        logic [63:0] exp_wr, exp_rd, prior_vm, got_wr;
        int          cyc, nreq, nwe, steps_bad;
        is_rd  = (op == 4'h5 || op == 4'h9 || op == 4'hB);
        is_wr  = (op == 4'h4 || op == 4'h8 || op == 4'hA);
        is_mem = is_rd || is_wr;
        base   = (op == 4'h9 || op == 4'hB) ? a[23:0] : e[23:0];
        exp_wr = (op == 4'h8) ? p : a;
        exp_rd = {mem_word(base), mem_word(base + 24'd1),
                  mem_word(base + 24'd2), mem_word(base + 24'd3)};
        prior_vm = val_m;
        got_wr = '0; first = '0; prev = '0;
        nreq = 0; nwe = 0; steps_bad = 0;
        @(negedge clk);
        opcode = op; cond_ok = c; val_e = e; val_a = a; val_p = p; val_c = t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            if (mem_req) begin
                if (nreq == 0) first = mem_addr;
                else if (mem_addr !== prev + 24'd1) steps_bad++;
                prev = mem_addr;
                if (mem_we) begin
                    nwe++;
                    got_wr = {got_wr[47:0], mem_wdata};
                end
                nreq++;
            end
            if (poke && nreq == 1) begin
                start = 1'b1; opcode = 4'h8; val_e = 64'h0; val_a = 64'h0;
                val_p = 64'h1; val_c = 64'h2; cond_ok = ~c;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk($sformatf("R6/R7 op=%h c=%0d done cycle", op, c), 64'(cyc), is_mem ? 64'd5 : 64'd1);
        chk($sformatf("R4/R7 op=%h word cycles", op), 64'(nreq), is_mem ? 64'd4 : 64'd0);
        chk($sformatf("R2 op=%h write cycles", op), 64'(nwe), is_wr ? 64'd4 : 64'd0);
        if (is_mem) begin
            chk($sformatf("R1 op=%h base address", op), 64'(first), 64'(base));
            chk($sformatf("R4 op=%h address steps", op), 64'(steps_bad), 64'd0);
        end
        if (is_wr)
            chk($sformatf("R5 op=%h store words", op), got_wr, exp_wr);
        chk($sformatf("R3 op=%h val_m", op), val_m, is_rd ? exp_rd : prior_vm);
        chk($sformatf("R8 op=%h c=%0d next_pc", op, c), next_pc,
            (op == 4'h7) ? (c ? t : p) : (op == 4'h8) ? t : (op == 4'h9) ? exp_rd : p);
        @(negedge clk);
        chk($sformatf("R6 op=%h done pulse width", op), 64'(done), 64'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; opcode = '0; cond_ok = 1'b0;
        val_e = '0; val_a = '0; val_p = '0; val_c = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 done after reset", 64'(done), 64'd0);
        chk("R10 mem_req after reset", 64'(mem_req), 64'd0);
        chk("R10 val_m after reset", val_m, 64'd0);

        // R1 R2 R3 R8 R11: full opcode and condition sweep, junk in upper address bits
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                run_op(4'(op), c[0], 64'hFEDC_BA98_7600_0123, 64'h0011_2233_44AB_0456,
                       64'h0000_0000_0000_5A5A, 64'h0000_0000_00C0_FFEE, 1'b0);
            end
        end

        // R4 wrap at the top of the address space for read and write
        run_op(4'hB, 1'b0, 64'h0, 64'hAAAA_0000_00FF_FFFE, 64'h10, 64'h20, 1'b0);
        run_op(4'h9, 1'b0, 64'h0, 64'h5555_0000_00FF_FFFF, 64'h10, 64'h20, 1'b0);
        run_op(4'hA, 1'b0, 64'h7700_0000_00FF_FFFD, 64'h0123_4567_89AB_CDEF, 64'h10, 64'h20, 1'b0);

        // R9 start pulse with changed operands during a transfer
        run_op(4'h5, 1'b1, 64'h0000_0000_0000_0080, 64'h0, 64'h0000_0000_0000_0777,
               64'h0000_0000_0000_0999, 1'b1);
        run_op(4'h4, 1'b0, 64'h0000_0000_0000_0033, 64'hCAFE_F00D_1234_8765,
               64'h0000_0000_0000_0444, 64'h0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule